// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block works out how a small 32-bit core enters a trap. Four request lines come in: a hardware exception, a memory-management fault, an external interrupt and a break. The core also supplies its program counter, its status word, its instruction-state flags (delay slot, after an immediate prefix, branch with immediate prefix) and a branch target. The vector base is an input, so software can move it. The fault kind and access kind for a memory fault arrive as inputs, and so do the cause and address for a hardware exception.

In the cycle a request is taken, the block chooses one winner. At the next clock edge it presents one registered update with these parts:
- the new program counter;
- the link value and the number of the register that receives it;
- the rewritten status word;
- the syndrome, fault-address and branch-target values, each with its own write enable;
- a pulse that drops the load reservation and clears the instruction-state flags.

The core applies all of these together.

Top module: `trap_entry_seq`

## Requirements
- R1: The new PC is the vector base plus 0x20 for a memory fault or a hardware exception, plus 0x18 for a break and plus 0x10 for an interrupt.
- R2: When several requests are present together, the winner is chosen in this order: memory fault first, then hardware exception, then break, then interrupt.
- R3: An interrupt is taken only when all of the following hold: status bit 1 (interrupt enable) is 1, status bit 9 (exception in progress) is 0, status bit 3 (break in progress) is 0, and both the delay-slot and immediate-prefix flags are 0. Otherwise it causes no update.
- R4: Interrupt entry writes the PC to link register 14 and clears status bit 1.
- R5: Break entry writes the PC to link register 16 and sets status bit 3.
- R6: Hardware exception entry writes PC+4 to link register 17 and sets status bit 9.
- R7: Memory-fault entry sets status bit 9 and writes a restart address to register 17. The address is the PC minus 8 for a delay slot with the branch-immediate flag set, and the PC minus 4 for any other delay slot. It is the PC minus 4 after an immediate prefix outside a delay slot, and the PC itself in every other case.
- R8: For a hardware exception or a memory fault, syndrome bit 12 equals the delay-slot flag. The branch target is written to the branch-target register only when that flag is set.
- R9: The memory-fault syndrome is 16, plus 1 for an instruction fetch, plus 2 for a miss (0 means a protection fault), plus 1024 (bit 10) for a store. The fault address is captured.
- R10: An unaligned hardware exception gives syndrome code 1. When the syndrome-valid flag is set, the 7 state bits are also copied into syndrome bits 11..5. The exception address is captured. A non-unaligned exception gives its 5-bit cause as the syndrome and writes no fault address.
- R11: Every entry copies status bits 11 (user mode) and 13 (virtual mode) into bits 12 and 14 and clears bits 11 and 13. Every other status bit not named here passes through unchanged.
- R12: Every entry pulses the reservation-clear and flag-clear outputs. Without an accepted request, including after reset, entry_valid and all write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 1 | Hardware exception request |
| mmu_req | input | 1 | Memory-management fault request |
| irq_req | input | 1 | External interrupt request |
| brk_req | input | 1 | Break request |
| pc_in | input | 32 | Current program counter |
| msr_in | input | 32 | Current status word |
| in_dslot | input | 1 | Instruction sits in a delay slot |
| after_imm | input | 1 | Instruction follows an immediate prefix |
| branch_imm | input | 1 | Delay-slot branch carried an immediate prefix |
| btarget | input | 32 | Pending branch target |
| vec_base | input | 32 | Vector base address |
| exc_cause | input | 5 | Cause code of a non-unaligned exception |
| exc_unaligned | input | 1 | Exception is an unaligned data access |
| exc_addr | input | 32 | Unaligned access address |
| ess_valid | input | 1 | Syndrome state bits are valid |
| ess_bits | input | 7 | Syndrome state bits |
| mmu_miss | input | 1 | 1 for a miss, 0 for a protection fault |
| mmu_fetch | input | 1 | Fault on an instruction fetch |
| mmu_store | input | 1 | Fault on a store |
| fault_addr | input | 32 | Faulting address |
| entry_valid | output | 1 | Update is valid this cycle |
| new_pc | output | 32 | Vector address |
| link_we | output | 1 | Link register write enable |
| link_sel | output | 5 | Link register number |
| link_val | output | 32 | Link value |
| new_msr | output | 32 | Updated status word |
| esr_we | output | 1 | Syndrome write enable |
| new_esr | output | 32 | Syndrome value |
| ear_we | output | 1 | Fault address write enable |
| new_ear | output | 32 | Fault address value |
| btr_we | output | 1 | Branch-target register write enable |
| new_btr | output | 32 | Branch-target value |
| clr_resv | output | 1 | Clear the load reservation |
| clr_iflags | output | 1 | Clear the instruction-state flags |

## Verification
Every result is held in one register stage. Each output therefore answers the inputs present at the previous rising edge and stays steady until the next edge. The bench sets each request pattern at a falling edge and reads every output at the following falling edge, exactly one edge later. It then drops all requests for one cycle and checks that no update appears. This confirms that a rejected or absent request changes nothing at the ports.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int XLEN       = 32,
  parameter int IE_BIT     = 1,
  parameter int BIP_BIT    = 3,
  parameter int EIP_BIT    = 9,
  parameter int UM_BIT     = 11,
  parameter int VM_BIT     = 13,
  parameter int ESR_DS_BIT = 12,
  parameter int ESS_LSB    = 5,
  parameter int ESS_W      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_req,
  input  logic            mmu_req,
  input  logic            irq_req,
  input  logic            brk_req,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] msr_in,
  input  logic            in_dslot,
  input  logic            after_imm,
  input  logic            branch_imm,
  input  logic [XLEN-1:0] btarget,
  input  logic [XLEN-1:0] vec_base,
  input  logic [4:0]      exc_cause,
  input  logic            exc_unaligned,
  input  logic [XLEN-1:0] exc_addr,
  input  logic            ess_valid,
  input  logic [ESS_W-1:0] ess_bits,
  input  logic            mmu_miss,
  input  logic            mmu_fetch,
  input  logic            mmu_store,
  input  logic [XLEN-1:0] fault_addr,
  output logic            entry_valid,
  output logic [XLEN-1:0] new_pc,
  output logic            link_we,
  output logic [4:0]      link_sel,
  output logic [XLEN-1:0] link_val,
  output logic [XLEN-1:0] new_msr,
  output logic            esr_we,
  output logic [XLEN-1:0] new_esr,
  output logic            ear_we,
  output logic [XLEN-1:0] new_ear,
  output logic            btr_we,
  output logic [XLEN-1:0] new_btr,
  output logic            clr_resv,
  output logic            clr_iflags
);
  localparam logic [XLEN-1:0] OFS_EXC = XLEN'(32'h20);
  localparam logic [XLEN-1:0] OFS_BRK = XLEN'(32'h18);
  localparam logic [XLEN-1:0] OFS_IRQ = XLEN'(32'h10);
  localparam logic [XLEN-1:0] CODE_UNALIGNED = XLEN'(1);

  logic irq_ok, t_mmu, t_exc, t_brk, t_irq, take;
  logic [XLEN-1:0] n_pc, n_link, n_msr, n_esr, n_ear, restart;
  logic [4:0] n_sel;
  logic n_ear_we;

  assign irq_ok = irq_req & msr_in[IE_BIT] & ~msr_in[EIP_BIT] & ~msr_in[BIP_BIT]
                  & ~in_dslot & ~after_imm;
  assign t_mmu = mmu_req;
  assign t_exc = exc_req & ~mmu_req;
  assign t_brk = brk_req & ~mmu_req & ~exc_req;
  assign t_irq = irq_ok & ~mmu_req & ~exc_req & ~brk_req;
  assign take  = t_mmu | t_exc | t_brk | t_irq;

  assign restart = in_dslot  ? pc_in - (branch_imm ? XLEN'(8) : XLEN'(4)) :
                   after_imm ? pc_in - XLEN'(4) : pc_in;

  always_comb begin
    n_msr = msr_in;
    n_pc = vec_base + OFS_IRQ;
    n_sel = 5'd14;
    n_link = pc_in;
    n_esr = '0;
    n_ear = fault_addr;
    n_ear_we = 1'b0;
    if (t_mmu) begin
      n_pc = vec_base + OFS_EXC;
      n_sel = 5'd17;
      n_link = restart;
      n_msr[EIP_BIT] = 1'b1;
      n_esr = XLEN'(16) | XLEN'({mmu_miss, mmu_fetch});
      n_esr[10] = mmu_store;
      n_ear_we = 1'b1;
    end else if (t_exc) begin
      n_pc = vec_base + OFS_EXC;
      n_sel = 5'd17;
      n_link = pc_in + XLEN'(4);
      n_msr[EIP_BIT] = 1'b1;
      if (exc_unaligned) begin
        n_esr = CODE_UNALIGNED;
        if (ess_valid) n_esr[ESS_LSB +: ESS_W] = ess_bits;
        n_ear = exc_addr;
        n_ear_we = 1'b1;
      end else begin
        n_esr = XLEN'(exc_cause);
      end
    end else if (t_brk) begin
      n_pc = vec_base + OFS_BRK;
      n_sel = 5'd16;
      n_msr[BIP_BIT] = 1'b1;
    end else begin
      n_msr[IE_BIT] = 1'b0;
    end
    n_esr[ESR_DS_BIT] = in_dslot;
    n_msr[VM_BIT+1] = msr_in[VM_BIT];
    n_msr[UM_BIT+1] = msr_in[UM_BIT];
    n_msr[VM_BIT] = 1'b0;
    n_msr[UM_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_valid <= 1'b0;
      link_we <= 1'b0;
      esr_we <= 1'b0;
      ear_we <= 1'b0;
      btr_we <= 1'b0;
      clr_resv <= 1'b0;
      clr_iflags <= 1'b0;
      new_pc <= '0;
      link_sel <= '0;
      link_val <= '0;
      new_msr <= '0;
      new_esr <= '0;
      new_ear <= '0;
      new_btr <= '0;
    end else begin
      entry_valid <= take;
      link_we <= take;
      esr_we <= t_mmu | t_exc;
      ear_we <= n_ear_we;
      btr_we <= (t_mmu | t_exc) & in_dslot;
      clr_resv <= take;
      clr_iflags <= take;
      if (take) begin
        new_pc <= n_pc;
        link_sel <= n_sel;
        link_val <= n_link;
        new_msr <= n_msr;
        new_esr <= n_esr;
        new_ear <= n_ear;
        if (in_dslot) new_btr <= btarget;
      end
    end
  end
endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int XLEN = 32,
  parameter int IE_BIT = 1,
  parameter int BIP_BIT = 3,
  parameter int UM_BIT = 11,
  parameter int VM_BIT = 13
) (
  input logic clk,
  input logic rst_n,
  input logic exc_req,
  input logic mmu_req,
  input logic irq_req,
  input logic brk_req,
  input logic [XLEN-1:0] msr_in,
  input logic in_dslot,
  input logic [XLEN-1:0] vec_base,
  input logic [XLEN-1:0] fault_addr,
  input logic entry_valid,
  input logic [XLEN-1:0] new_pc,
  input logic [4:0] link_sel,
  input logic [XLEN-1:0] new_msr,
  input logic ear_we,
  input logic [XLEN-1:0] new_ear,
  input logic clr_resv,
  input logic clr_iflags
);
  assert_mmu_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_req |=> entry_valid && new_pc == $past(vec_base) + XLEN'(32'h20));
  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !exc_req && !mmu_req && !brk_req && (!msr_in[IE_BIT] || in_dslot))
    |=> !entry_valid);
  assert_break_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !mmu_req && !exc_req) |=> link_sel == 5'd16 && new_msr[BIP_BIT]);
  assert_fault_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_req |=> ear_we && new_ear == $past(fault_addr));
  assert_mode_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> !new_msr[VM_BIT] && !new_msr[UM_BIT]);
  assert_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    entry_valid |-> clr_resv && clr_iflags);
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_req || mmu_req || irq_req || brk_req) |=> !entry_valid);
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
  .XLEN(XLEN), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT), .UM_BIT(UM_BIT), .VM_BIT(VM_BIT)
) chk (.*);

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic exc_req = 0, mmu_req = 0, irq_req = 0, brk_req = 0;
  logic [31:0] pc_in = 0, msr_in = 0, btarget = 0, vec_base = 0, exc_addr = 0, fault_addr = 0;
  logic in_dslot = 0, after_imm = 0, branch_imm = 0, exc_unaligned = 0, ess_valid = 0;
  logic [4:0] exc_cause = 0;
  logic [6:0] ess_bits = 0;
  logic mmu_miss = 0, mmu_fetch = 0, mmu_store = 0;
  logic entry_valid, link_we, esr_we, ear_we, btr_we, clr_resv, clr_iflags;
  logic [31:0] new_pc, link_val, new_msr, new_esr, new_ear, new_btr;
  logic [4:0] link_sel;

  trap_entry_seq uut (.*);

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // kinds: 0 none, 1 mmu, 2 exc, 3 brk, 4 irq
  task automatic apply_and_check();
    int kind;
    logic irq_ok;
    logic [31:0] e_pc, e_link, e_msr, e_esr;
    logic [4:0] e_sel;
    irq_ok = irq_req && msr_in[1] && !msr_in[9] && !msr_in[3] && !in_dslot && !after_imm;
    kind = mmu_req ? 1 : exc_req ? 2 : brk_req ? 3 : irq_ok ? 4 : 0;
    e_msr = msr_in;
    e_esr = 0;
    e_sel = 14;
    e_link = pc_in;
    e_pc = vec_base + 32'h10;
    case (kind)
      1: begin
        e_pc = vec_base + 32'h20; e_sel = 17; e_msr[9] = 1;
        e_link = in_dslot ? pc_in - (branch_imm ? 8 : 4) : after_imm ? pc_in - 4 : pc_in;
        e_esr = 16 + (mmu_fetch ? 1 : 0) + (mmu_miss ? 2 : 0) + (mmu_store ? 1024 : 0);
      end
      2: begin
        e_pc = vec_base + 32'h20; e_sel = 17; e_msr[9] = 1; e_link = pc_in + 4;
        e_esr = exc_unaligned ? (1 + (ess_valid ? {20'd0, ess_bits, 5'd0} : 0)) : {27'd0, exc_cause};
      end
      3: begin e_pc = vec_base + 32'h18; e_sel = 16; e_msr[3] = 1; end
      4: e_msr[1] = 0;
      default: ;
    endcase
    if (in_dslot) e_esr = e_esr + 32'h1000;
    e_msr[12] = msr_in[11]; e_msr[14] = msr_in[13]; e_msr[11] = 0; e_msr[13] = 0;
    @(negedge clk);
    chk(kind == 0 ? "R3" : "R2", "entry_valid", {31'd0, entry_valid}, {31'd0, kind != 0});
    chk("R12", "clears", {30'd0, clr_resv, clr_iflags}, kind != 0 ? 32'd3 : 32'd0);
    if (kind != 0) begin
      chk("R1", "new_pc", new_pc, e_pc);
      chk(kind == 1 ? "R7" : kind == 2 ? "R6" : kind == 3 ? "R5" : "R4", "link",
          {link_sel, link_val[26:0]}, {e_sel, e_link[26:0]});
      chk(kind == 1 ? "R7" : kind == 2 ? "R6" : kind == 3 ? "R5" : "R4", "link_hi",
          {27'd0, link_we, link_val[31:27]}, {27'd0, 1'b1, e_link[31:27]});
      chk("R11", "new_msr", new_msr, e_msr);
      chk("R8", "btr_we", {31'd0, btr_we}, {31'd0, (kind <= 2) && in_dslot});
      if (kind <= 2 && in_dslot) chk("R8", "new_btr", new_btr, btarget);
      chk(kind == 1 ? "R9" : "R10", "esr_we", {31'd0, esr_we}, {31'd0, kind <= 2});
      if (kind <= 2) chk(kind == 1 ? "R9" : "R10", "new_esr", new_esr, e_esr);
      chk(kind == 1 ? "R9" : "R10", "ear_we", {31'd0, ear_we},
          {31'd0, kind == 1 || (kind == 2 && exc_unaligned)});
      if (kind == 1) chk("R9", "new_ear", new_ear, fault_addr);
      if (kind == 2 && exc_unaligned) chk("R10", "new_ear", new_ear, exc_addr);
    end else begin
      chk("R12", "write_enables", {28'd0, link_we, esr_we, ear_we, btr_we}, 32'd0);
    end
    {exc_req, mmu_req, irq_req, brk_req} = 0;
    @(negedge clk);
    chk("R12", "idle_after", {31'd0, entry_valid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n = 0;
    repeat (3) @(negedge clk);
    chk("R12", "reset_valid", {28'd0, entry_valid, link_we, esr_we, ear_we},  32'd0);
    chk("R12", "reset_clears", {29'd0, btr_we, clr_resv, clr_iflags}, 32'd0);
    rst_n = 1;
    for (int rq = 0; rq < 16; rq++)
      for (int fl = 0; fl < 8; fl++)
        for (int ms = 0; ms < 32; ms++)
          for (int ft = 0; ft < 8; ft += (rq[0] ? 1 : 7)) begin
            n++;
            {mmu_req, exc_req, brk_req, irq_req} = rq[3:0];
            {branch_imm, after_imm, in_dslot} = fl[2:0];
            msr_in = 32'h0010_0001 | (ms[0] ? 32'h2 : 0) | (ms[1] ? 32'h8 : 0)
                   | (ms[2] ? 32'h200 : 0) | (ms[3] ? 32'h800 : 32'h1000)
                   | (ms[4] ? 32'h2000 : 32'h4000);
            {mmu_store, mmu_fetch, mmu_miss} = ft[2:0];
            pc_in = 32'h0000_1000 + n * 4;
            btarget = 32'h0008_0000 ^ (n * 16);
            vec_base = 32'h4000_0000 ^ (n << 8);
            fault_addr = 32'hA000_0000 + n;
            exc_cause = 5'(n);
            exc_unaligned = 0;
            apply_and_check();
          end
    for (int ev = 0; ev < 2; ev++)
      for (int eb = 0; eb < 128; eb += 5)
        for (int ds = 0; ds < 2; ds++) begin
          {mmu_req, brk_req, irq_req} = 0;
          exc_req = 1;
          exc_unaligned = 1;
          ess_valid = ev[0];
          ess_bits = 7'(eb);
          in_dslot = ds[0]; after_imm = 0; branch_imm = 0;
          msr_in = 32'h0000_2802;
          exc_addr = 32'h7000_0003 + eb;
          pc_in = 32'h0000_0200 + eb * 4;
          btarget = 32'h0000_9000 + eb;
          vec_base = 32'h0000_0100;
          apply_and_check();
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule